// File: doc/BRIEF.md
# Sense-Reversing Barrier Unit

This block lets a group of processors meet at a barrier. Each processor signals that it has reached the barrier with a one-cycle pulse on its bit of `arrive`. It then stalls for as long as its bit of `waitOut` is high. The unit keeps a shared tally of arrivals for the current round. When the arrival that completes the group is accepted, the tally clears and a single global release flag inverts. This releases every waiter in the same cycle.

Every processor has a private sense bit, which inverts each time its arrival is accepted. A processor waits while the global flag differs from its sense bit. Because the value being waited for alternates from one round to the next, a processor that is slow to notice a release is never stranded. The flag cannot move again until that processor has itself arrived at the next barrier. An arrive pulse from a processor that is still waiting is a protocol violation. The unit discards it and raises an error strobe.

Top module: `barrier_sync`

## Requirements
- R1: After reset, `arrivedCount` is 0, `releaseFlag` is 0, every `localSense` bit is 0, every `waitOut` bit is 0 and `dupError` is 0.
- R2: An accepted arrival of processor i is a pulse on `arrive[i]` while `waitOut[i]` is low. It inverts `localSense[i]` on the following clock edge. No other event changes `localSense[i]`.
- R3: `waitOut[i]` is high exactly when `releaseFlag` differs from `localSense[i]`. It follows those registers in the same cycle.
- R4: On each clock edge, `arrivedCount` grows by the number of arrivals accepted in that cycle. Simultaneous arrivals in one cycle are all counted.
- R5: When an edge would bring the tally to NUM_PROCS, `arrivedCount` becomes 0 and `releaseFlag` inverts on that same edge. As a result, every `waitOut` bit is low in the next cycle.
- R6: The release value alternates between rounds: the first completed barrier sets `releaseFlag` to 1, the second returns it to 0, and so on.
- R7: An arrive pulse from a processor whose `waitOut` bit is high leaves its sense bit and the tally unchanged. It makes `dupError` high for exactly the next cycle.
- R8: After a release, other processors may arrive at the next barrier before a slow processor does. In that case the slow processor's `waitOut` stays low, and `releaseFlag` does not change until the slow processor has arrived too.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| arrive | input | NUM_PROCS | One-cycle arrival pulse per processor |
| waitOut | output | NUM_PROCS | High while the processor must stall at the barrier |
| localSense | output | NUM_PROCS | Private sense bit of each processor |
| releaseFlag | output | 1 | Global release flag, inverted once per completed barrier |
| arrivedCount | output | $clog2(NUM_PROCS+1) | Arrivals accepted so far in the current round |
| dupError | output | 1 | High for one cycle after an arrive from a waiting processor |

## Verification
The hardest situation to reach is the overlap of two rounds. Fast processors must already be arriving at the next barrier while a slow one has not yet re-arrived. Duplicate pulses must also land in the same cycle as a completing arrival. The stimulus builds this directly. It releases a round, then fires the fast processors again and holds back the last one. It then mixes the withheld arrival with pulses from processors that are already waiting. A long stretch of random arrive vectors follows, including illegal duplicates. A behavioural reference model checks every output after every edge.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
  // strobes passed from control to datapath each cycle
  typedef struct packed {
    logic wrap;  // this edge completes the barrier
    logic dup;   // an arrive came from a processor still waiting
  } ctlStrobe_t;
endpackage

// File: rtl/barrier_datapath.sv
module barrier_datapath
  import barrier_pkg::*;
#(
  parameter int NUM_PROCS = 4,
  localparam int CW = $clog2(NUM_PROCS + 1),
  localparam int SW = $clog2(2 * NUM_PROCS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PROCS-1:0] accept,
  input  ctlStrobe_t           strobe,
  output logic [NUM_PROCS-1:0] waitVec,
  output logic [NUM_PROCS-1:0] senseVec,
  output logic                 flag,
  output logic [CW-1:0]        count,
  output logic [SW-1:0]        nextTotal,
  output logic                 dupReg
);
  logic [SW-1:0] acceptPop;

  // population count of accepted arrivals
  always_comb begin
    acceptPop = '0;
    for (int i = 0; i < NUM_PROCS; i++) begin
      acceptPop = acceptPop + SW'(accept[i]);
    end
    nextTotal = SW'(count) + acceptPop;
  end

  // per-processor private sense registers
  for (genvar g = 0; g < NUM_PROCS; g++) begin : gSense
    always_ff @(posedge clk) begin
      if (!rstN) begin
        senseVec[g] <= 1'b0;
      end else if (accept[g]) begin
        senseVec[g] <= ~senseVec[g];
      end
    end
    assign waitVec[g] = flag ^ senseVec[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= '0;
      flag   <= 1'b0;
      dupReg <= 1'b0;
    end else begin
      dupReg <= strobe.dup;
      if (strobe.wrap) begin
        count <= '0;
        flag  <= ~flag;
      end else begin
        count <= CW'(nextTotal);
      end
    end
  end
endmodule

// File: rtl/barrier_control.sv
module barrier_control
  import barrier_pkg::*;
#(
  parameter int NUM_PROCS = 4,
  localparam int SW = $clog2(2 * NUM_PROCS + 1)
) (
  input  logic [NUM_PROCS-1:0] arrive,
  input  logic [NUM_PROCS-1:0] waitVec,
  input  logic [SW-1:0]        nextTotal,
  output logic [NUM_PROCS-1:0] accept,
  output ctlStrobe_t           strobe
);
  always_comb begin
    accept      = arrive & ~waitVec;
    strobe.dup  = |(arrive & waitVec);
    strobe.wrap = (nextTotal == SW'(NUM_PROCS));
  end
endmodule

// File: rtl/barrier_sync.sv
module barrier_sync
  import barrier_pkg::*;
#(
  parameter int NUM_PROCS = 4,
  localparam int CW = $clog2(NUM_PROCS + 1),
  localparam int SW = $clog2(2 * NUM_PROCS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PROCS-1:0] arrive,
  output logic [NUM_PROCS-1:0] waitOut,
  output logic [NUM_PROCS-1:0] localSense,
  output logic                 releaseFlag,
  output logic [CW-1:0]        arrivedCount,
  output logic                 dupError
);
  logic [NUM_PROCS-1:0] acceptVec;
  logic [SW-1:0]        nextTotal;
  ctlStrobe_t           strobe;

  barrier_control #(.NUM_PROCS(NUM_PROCS)) u_ctl (
    .arrive   (arrive),
    .waitVec  (waitOut),
    .nextTotal(nextTotal),
    .accept   (acceptVec),
    .strobe   (strobe)
  );

  barrier_datapath #(.NUM_PROCS(NUM_PROCS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .accept   (acceptVec),
    .strobe   (strobe),
    .waitVec  (waitOut),
    .senseVec (localSense),
    .flag     (releaseFlag),
    .count    (arrivedCount),
    .nextTotal(nextTotal),
    .dupReg   (dupError)
  );
endmodule

// File: rtl/barrier_sync_checker.sv
module barrier_sync_checker #(
  parameter int NUM_PROCS = 4,
  localparam int CW = $clog2(NUM_PROCS + 1)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_PROCS-1:0] arrive,
  input logic [NUM_PROCS-1:0] waitOut,
  input logic [NUM_PROCS-1:0] localSense,
  input logic                 releaseFlag,
  input logic [CW-1:0]        arrivedCount,
  input logic                 dupError
);
  assert_count_below_R4: assert property (@(posedge clk) disable iff (!rstN)
    arrivedCount < CW'(NUM_PROCS));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (arrive == '0) |=> ($stable(arrivedCount) && $stable(releaseFlag) && $stable(localSense)));

  assert_release_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(releaseFlag) |-> (arrivedCount == '0 && waitOut == '0));

  assert_dup_flagged_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((arrive & waitOut) != '0) |=> dupError);

  assert_no_spurious_dup_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((arrive & waitOut) == '0) |=> !dupError);

  assert_sense_moves_on_arrive_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((arrive & ~waitOut) == '0) |=> $stable(localSense));
endmodule

bind barrier_sync barrier_sync_checker #(.NUM_PROCS(NUM_PROCS)) u_chk (
  .clk(clk), .rstN(rstN), .arrive(arrive), .waitOut(waitOut),
  .localSense(localSense), .releaseFlag(releaseFlag),
  .arrivedCount(arrivedCount), .dupError(dupError)
);

// File: tb/barrier_sync_tb.sv
`timescale 1ns/1ps
module barrier_sync_tb;
  localparam int P  = 4;
  localparam int CW = $clog2(P + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [P-1:0]  arrive = '0;
  logic [P-1:0]  waitOut, localSense;
  logic          releaseFlag, dupError;
  logic [CW-1:0] arrivedCount;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference state
  int refCount = 0;
  bit refFlag = 0;
  bit refSense [P];
  bit refDup = 0;

  always #2 clk = ~clk;  // 250 MHz

  barrier_sync #(.NUM_PROCS(P)) u_dut (
    .clk(clk), .rstN(rstN), .arrive(arrive), .waitOut(waitOut),
    .localSense(localSense), .releaseFlag(releaseFlag),
    .arrivedCount(arrivedCount), .dupError(dupError)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expWait();
    int w = 0;
    for (int i = 0; i < P; i++) if (refFlag != refSense[i]) w |= (1 << i);
    return w;
  endfunction

  function automatic int expSense();
    int s = 0;
    for (int i = 0; i < P; i++) if (refSense[i]) s |= (1 << i);
    return s;
  endfunction

  task automatic compareAll();
    check(int'(waitOut) == expWait(), "R3 waitOut", int'(waitOut), expWait());
    check(int'(localSense) == expSense(), "R2 localSense", int'(localSense), expSense());
    check(int'(arrivedCount) == refCount, "R4 arrivedCount", int'(arrivedCount), refCount);
    check(releaseFlag == refFlag, "R5 releaseFlag", int'(releaseFlag), int'(refFlag));
    check(dupError == refDup, "R7 dupError", int'(dupError), int'(refDup));
  endtask

  // drive one arrive vector for one cycle, advance model, compare
  task automatic step(input logic [P-1:0] a);
    int acc = 0;
    bit dup = 0;
    arrive = a;
    for (int i = 0; i < P; i++) begin
      if (a[i]) begin
        if (refFlag != refSense[i]) dup = 1;
        else begin
          acc++;
          refSense[i] = !refSense[i];
        end
      end
    end
    refCount += acc;
    if (refCount == P) begin
      refCount = 0;
      refFlag = !refFlag;
    end
    refDup = dup;
    @(posedge clk);
    #1;
    arrive = '0;
    compareAll();
  endtask

  initial begin
    for (int i = 0; i < P; i++) refSense[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    // R1 reset state
    check(arrivedCount == '0, "R1 count", int'(arrivedCount), 0);
    check(releaseFlag == 1'b0, "R1 flag", int'(releaseFlag), 0);
    check(localSense == '0, "R1 sense", int'(localSense), 0);
    check(waitOut == '0, "R1 wait", int'(waitOut), 0);
    check(dupError == 1'b0, "R1 dup", int'(dupError), 0);

    // sequential arrivals, first barrier
    step(4'b0001); step(4'b0000); step(4'b0010); step(4'b0100);
    step(4'b1000);
    check(releaseFlag == 1'b1, "R6 first release to 1", int'(releaseFlag), 1);
    check(waitOut == '0, "R5 all released", int'(waitOut), 0);

    // all at once, second barrier
    step(4'b1111);
    check(releaseFlag == 1'b0, "R6 second release to 0", int'(releaseFlag), 0);

    // two plus two, with duplicates in between
    step(4'b0011);
    step(4'b0001);  // duplicate from waiting processor
    check(arrivedCount == CW'(2), "R7 dup ignored count", int'(arrivedCount), 2);
    step(4'b1110);  // 1 dup, 2 and 3 complete
    check(dupError == 1'b1, "R7 dup with completion", int'(dupError), 1);
    step(4'b0000);
    check(dupError == 1'b0, "R7 dup single cycle", int'(dupError), 0);

    // slow processor: 3 is late for the next round
    step(4'b0111);
    check(waitOut[3] == 1'b0, "R8 slow proc not waiting", int'(waitOut[3]), 0);
    check(releaseFlag == refFlag, "R8 flag held", int'(releaseFlag), int'(refFlag));
    step(4'b0111);  // all duplicates
    step(4'b0000);
    check(waitOut == 4'b0111, "R8 fast procs still wait", int'(waitOut), 7);
    step(4'b1000);
    check(waitOut == '0, "R8 slow arrival releases all", int'(waitOut), 0);

    // random traffic
    for (int n = 0; n < 400; n++) step(4'($urandom_range(0, 15)));

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule